// File: doc/BRIEF.md
# DMA Channel Event Capture Controller

This block records synchronization events for 64 DMA channels and picks the channel that submits the next transfer request. A channel can be triggered in three ways: its own fixed hardware event line, a software write to the set register, or a chaining pulse that reports the completion or intermediate completion of another transfer. Events are recorded whether or not the channel is enabled. A recorded event waits until its enable bit is set, and only then is it offered downstream.

The request side is a valid/ready stream that carries one channel number. The parameter-fetch stage takes the channel on the cycle where `req_valid` and `req_ready` are both high. The pending bit of that channel clears on that same edge.

Back-pressure rules:
- While `req_ready` is low, nothing is consumed.
- `req_valid` stays high for as long as any channel is both pending and enabled.
- `req_chan` always shows the lowest-numbered eligible channel. It can therefore move to a lower channel before acceptance. Only the value present at the handshake counts.

Control and status go through a simple word register port. Writes take effect at the clock edge, and reads are combinational.

Top module: `dma_evt_capture`

## Requirements
- R1: The address is {function[2:0], word[0]}. Word 0 covers channels 0..31 and word 1 covers channels 32..63. Function codes: 0 pending (read only), 1 enable (read/write), 2 set (write 1 to set), 3 clear (write 1 to clear pending), 4 missed-event (read, write 1 to clear). After reset all pending, enable and missed bits are 0 and `req_valid` is 0.
- R2: A pulse on `hw_evt[i]` sets pending bit i, even when enable bit i is clear.
- R3: Writing the set register sets each pending bit written as 1. Bits written as 0 have no effect.
- R4: A pulse on `chain_evt[i]` sets pending bit i.
- R5: `req_valid` is high exactly when some channel is both pending and enabled. A masked pending event is kept, and it is offered once its enable bit is written to 1.
- R6: When several channels are eligible, `req_chan` is the lowest-numbered one.
- R7: A handshake clears the pending bit of `req_chan` at that edge. If a trigger for the same channel arrives in the handshake cycle, the bit stays set and no missed event is flagged.
- R8: A trigger for a channel whose pending bit is set, and that is not being cleared in that cycle, sets its missed-event bit. Writing 1 clears a missed-event bit. A new miss in the same cycle wins over that clear.
- R9: Writing the clear register clears each pending bit written as 1. A trigger for that channel in the same cycle wins, and the bit stays set.
- R10: The enable words read back what was written. Reads of the set and clear functions return 0.
- R11: While `req_ready` is low, no pending bit is consumed. If a lower-numbered channel becomes eligible, `req_chan` moves to it before acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_evt | input | 64 | One-cycle hardware event pulse per channel |
| chain_evt | input | 64 | One-cycle chaining pulse per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address {function, word} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Transfer request available |
| req_chan | output | 6 | Channel of the offered request |
| req_ready | input | 1 | Downstream accepts the request |

## Verification
Several functions can meet on one channel in the same cycle:
- A handshake that consumes a channel while a fresh hardware event for that channel arrives.
- A clear-register write together with a trigger.
- A missed-event clear together with a new miss.

Each case is provoked by driving both stimuli in one cycle. The case is judged by reading the pending and missed-event words afterwards: the new trigger must survive, and no false miss may appear. Another overlap is a set-register write that makes a lower channel eligible while a request is held back by `req_ready`. For that case the bench checks that `req_chan` switches before acceptance.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_PEND = 3'd0,
    FN_EN   = 3'd1,
    FN_SET  = 3'd2,
    FN_CLR  = 3'd3,
    FN_MISS = 3'd4
  } cfg_fn_e;
endpackage

// File: rtl/evt_regif.sv
module evt_regif
  import dma_evt_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int REG_W  = 32,
  localparam int NWORD  = NUM_CH / REG_W,
  localparam int WSEL_W = $clog2(NWORD),
  localparam int ADDR_W = FN_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] miss,
  output logic [NUM_CH-1:0] en,
  output logic [NUM_CH-1:0] set_vec,
  output logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] miss_clr_vec
);
  logic [FN_W-1:0]   fn;
  logic [WSEL_W-1:0] wsel;
  logic [REG_W-1:0]  en_w [NWORD];

  assign fn   = cfg_addr[ADDR_W-1:WSEL_W];
  assign wsel = cfg_addr[WSEL_W-1:0];

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic hit;
    assign hit = cfg_we && (wsel == WSEL_W'(w));

    assign set_vec[w*REG_W +: REG_W]      = (hit && fn == FN_SET)  ? cfg_wdata : '0;
    assign clr_vec[w*REG_W +: REG_W]      = (hit && fn == FN_CLR)  ? cfg_wdata : '0;
    assign miss_clr_vec[w*REG_W +: REG_W] = (hit && fn == FN_MISS) ? cfg_wdata : '0;
    assign en[w*REG_W +: REG_W]           = en_w[w];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    en_w[w] <= '0;
      else if (hit && fn == FN_EN)   en_w[w] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (fn)
      FN_PEND: cfg_rdata = pend[wsel*REG_W +: REG_W];
      FN_EN:   cfg_rdata = en[wsel*REG_W +: REG_W];
      FN_MISS: cfg_rdata = miss[wsel*REG_W +: REG_W];
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_bank.sv
module evt_bank #(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hw_evt,
  input  logic [NUM_CH-1:0] chain_evt,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  input  logic [NUM_CH-1:0] ack_vec,
  input  logic [NUM_CH-1:0] miss_clr_vec,
  output logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] miss
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic trig, drop, lost;
    assign trig = hw_evt[c] | chain_evt[c] | set_vec[c];
    assign drop = clr_vec[c] | ack_vec[c];
    assign lost = trig & pend[c] & ~drop;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[c] <= 1'b0;
        miss[c] <= 1'b0;
      end else begin
        pend[c] <= trig | (pend[c] & ~drop);
        miss[c] <= lost | (miss[c] & ~miss_clr_vec[c]);
      end
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM_CH = 64,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] elig,
  output logic              any,
  output logic [CH_W-1:0]   idx
);
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) idx = CH_W'(i);
    end
  end
endmodule

// File: rtl/dma_evt_capture.sv
module dma_evt_capture
  import dma_evt_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int REG_W  = 32,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = FN_W + $clog2(NUM_CH / REG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hw_evt,
  input  logic [NUM_CH-1:0] chain_evt,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              req_valid,
  output logic [CH_W-1:0]   req_chan,
  input  logic              req_ready
);
  logic [NUM_CH-1:0] pend_q, miss_q, en_q;
  logic [NUM_CH-1:0] set_v, clr_v, mclr_v, ack_v;

  evt_regif #(.NUM_CH(NUM_CH), .REG_W(REG_W)) regif_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pend(pend_q), .miss(miss_q), .en(en_q),
    .set_vec(set_v), .clr_vec(clr_v), .miss_clr_vec(mclr_v)
  );

  evt_bank #(.NUM_CH(NUM_CH)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .hw_evt(hw_evt), .chain_evt(chain_evt),
    .set_vec(set_v), .clr_vec(clr_v), .ack_vec(ack_v), .miss_clr_vec(mclr_v),
    .pend(pend_q), .miss(miss_q)
  );

  prio_pick #(.NUM_CH(NUM_CH)) pick_i (
    .elig(pend_q & en_q), .any(req_valid), .idx(req_chan)
  );

  assign ack_v = (req_valid && req_ready) ? (NUM_CH'(1) << req_chan) : '0;
endmodule

// File: rtl/dma_evt_capture_chk.sv
module dma_evt_capture_chk #(
  parameter int NUM_CH = 64,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] hw_evt,
  input logic [NUM_CH-1:0] chain_evt,
  input logic [NUM_CH-1:0] set_vec,
  input logic [NUM_CH-1:0] clr_vec,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] en,
  input logic [NUM_CH-1:0] miss,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CH_W-1:0]   req_chan
);
  logic [NUM_CH-1:0] trig, hs, miss_ev, clr_only;
  assign trig     = hw_evt | chain_evt | set_vec;
  assign hs       = (req_valid && req_ready) ? (NUM_CH'(1) << req_chan) : '0;
  assign miss_ev  = trig & pend & ~(clr_vec | hs);
  assign clr_only = clr_vec & ~trig;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |=> ((pend & $past(trig)) == $past(trig)));

  assert_grant_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (pend[req_chan] && en[req_chan]));

  assert_idle_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ((pend & en) == '0));

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((pend & en & ((NUM_CH'(1) << req_chan) - NUM_CH'(1))) == '0));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !trig[req_chan]) |=> !pend[$past(req_chan)]);

  assert_miss_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ev != '0) |=> ((miss & $past(miss_ev)) == $past(miss_ev)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_only != '0) |=> ((pend & $past(clr_only)) == '0));
endmodule

bind dma_evt_capture dma_evt_capture_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .chain_evt(chain_evt),
  .set_vec(set_v), .clr_vec(clr_v), .pend(pend_q), .en(en_q), .miss(miss_q),
  .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan)
);

// File: tb/dma_evt_capture_tb_top.sv
module dma_evt_capture_tb_top;
  localparam logic [3:0] A_PEND_LO = 4'd0, A_PEND_HI = 4'd1, A_EN_LO = 4'd2, A_EN_HI = 4'd3,
                         A_SET_LO = 4'd4, A_SET_HI = 4'd5, A_CLR_LO = 4'd6, A_CLR_HI = 4'd7,
                         A_MISS_LO = 4'd8, A_MISS_HI = 4'd9;

  logic        clk = 0, rst_n = 0;
  logic [63:0] hw_evt = '0, chain_evt = '0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid, req_ready = 0;
  logic [5:0]  req_chan;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_evt_capture dut_i (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .chain_evt(chain_evt),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_chan(req_chan), .req_ready(req_ready)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, called and returning at a falling edge
  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                      input logic [63:0] hw, input logic [63:0] ch, input logic rdy);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; hw_evt = hw; chain_evt = ch; req_ready = rdy;
    @(negedge clk);
    cfg_we = 0; hw_evt = '0; chain_evt = '0; req_ready = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0, '0, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic cleanup();
    wr(A_EN_LO, '0); wr(A_EN_HI, '0);
    wr(A_CLR_LO, '1); wr(A_CLR_HI, '1);
    wr(A_MISS_LO, '1); wr(A_MISS_HI, '1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_PEND_LO, d); chk("R1 pend_lo reset", d, 0);
    rd(A_PEND_HI, d); chk("R1 pend_hi reset", d, 0);
    rd(A_EN_HI, d);   chk("R1 en_hi reset", d, 0);
    rd(A_MISS_LO, d); chk("R1 miss_lo reset", d, 0);
    chk("R1 valid reset", req_valid, 0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    step(0, A_PEND_LO, 0, 64'h20, '0, 0);
    rd(A_PEND_LO, d); chk("R2 masked capture", d, 32'h20);
    chk("R5 masked not offered", req_valid, 0);
    wr(A_EN_LO, 32'h20);
    chk("R5 offered after enable", {req_valid, req_chan}, {1'b1, 6'd5});
    step(0, A_PEND_LO, 0, '0, '0, 1);
    rd(A_PEND_LO, d); chk("R7 ack clears", d, 0);
    chk("R7 valid drops", req_valid, 0);
    cleanup();
  endtask

  task automatic t_sw_set();
    logic [31:0] d;
    wr(A_SET_HI, 32'h1);
    wr(A_SET_HI, 32'h0);
    rd(A_PEND_HI, d); chk("R3 set bit32, zero write no effect", d, 32'h1);
    wr(A_CLR_HI, 32'h1);
    rd(A_PEND_HI, d); chk("R9 clear register", d, 0);
    cleanup();
  endtask

  task automatic t_chain();
    logic [31:0] d;
    step(0, A_PEND_HI, 0, '0, 64'h1 << 40, 0);
    rd(A_PEND_HI, d); chk("R4 chain sets ch40", d, 32'h100);
    cleanup();
  endtask

  task automatic t_prio();
    wr(A_SET_LO, (32'h1 << 3) | (32'h1 << 10));
    wr(A_SET_HI, 32'h100);
    wr(A_EN_LO, '1); wr(A_EN_HI, '1);
    chk("R6 lowest first", req_chan, 3);
    wr(A_SET_LO, 32'h2);
    chk("R11 lower channel takes over while held", {req_valid, req_chan}, {1'b1, 6'd1});
    step(0, A_PEND_LO, 0, '0, '0, 1); chk("R6 next is 3", req_chan, 3);
    step(0, A_PEND_LO, 0, '0, '0, 1); chk("R6 next is 10", req_chan, 10);
    step(0, A_PEND_LO, 0, '0, '0, 1); chk("R6 next is 40", req_chan, 40);
    step(0, A_PEND_LO, 0, '0, '0, 1); chk("R7 all consumed", req_valid, 0);
    cleanup();
  endtask

  task automatic t_ack_collide();
    logic [31:0] d;
    wr(A_SET_LO, 32'h80); wr(A_EN_LO, 32'h80);
    step(0, A_PEND_LO, 0, 64'h80, '0, 1);
    rd(A_PEND_LO, d); chk("R7 new event survives ack", d, 32'h80);
    rd(A_MISS_LO, d); chk("R7 no miss on ack collision", d, 0);
    cleanup();
  endtask

  task automatic t_miss();
    logic [31:0] d;
    step(0, A_PEND_LO, 0, 64'h1 << 20, '0, 0);
    step(0, A_PEND_LO, 0, 64'h1 << 20, '0, 0);
    rd(A_MISS_LO, d); chk("R8 miss set", d, 32'h1 << 20);
    wr(A_MISS_LO, 32'h0);
    rd(A_MISS_LO, d); chk("R8 zero write keeps miss", d, 32'h1 << 20);
    step(1, A_MISS_LO, 32'h1 << 20, 64'h1 << 20, '0, 0);
    rd(A_MISS_LO, d); chk("R8 new miss beats clear", d, 32'h1 << 20);
    wr(A_MISS_LO, 32'h1 << 20);
    rd(A_MISS_LO, d); chk("R8 write 1 clears miss", d, 0);
    cleanup();
  endtask

  task automatic t_clr_collide();
    logic [31:0] d;
    wr(A_SET_LO, 32'h1000);
    step(1, A_CLR_LO, 32'h1000, 64'h1000, '0, 0);
    rd(A_PEND_LO, d); chk("R9 trigger beats clear", d, 32'h1000);
    rd(A_MISS_LO, d); chk("R9 no miss when cleared", d, 0);
    cleanup();
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_EN_HI, 32'hA5A5_0000);
    rd(A_EN_HI, d);  chk("R10 enable readback", d, 32'hA5A5_0000);
    rd(A_SET_LO, d); chk("R10 set reads zero", d, 0);
    rd(A_CLR_HI, d); chk("R10 clear reads zero", d, 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_sw_set();
    t_chain();
    t_prio();
    t_ack_collide();
    t_miss();
    t_clr_collide();
    t_regs();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule